// File: doc/BRIEF.md
# SDRAM Per-Bank Command Legality Tracker

This block sits beside the command bus of a DDR2-style SDRAM and watches every command the controller issues. It decodes the strobe lines (chip select, row strobe, column strobe, write enable), the bank address and the auto-precharge address bit. Each bank has a small state machine that follows what the memory itself would be doing: idle, opening a row, row open, bursting, closing the row, or bursting with a close queued behind it. The opening and closing phases run for the number of cycles held in two timing inputs.

Any command that the addressed bank may not accept in its present state is flagged. The tracker raises a one-cycle pulse, reports a reason code and sets a sticky flag, and the bank state is left as it was. The live state of every bank is driven out, so a monitor or an assertion harness can follow the device. Commands are checked only while the clock enable has been high for two consecutive samples.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: Commands are decoded from {csN,rasN,casN,weN}: csN=1 is DESELECT. With csN=0 the other three lines give 111 NOP, 011 ACTIVATE, 101 READ, 100 WRITE, 010 PRECHARGE, 001 REFRESH and 000 LOAD MODE. Pattern 110 is treated as NOP. apBit selects auto-precharge on READ/WRITE and all banks on PRECHARGE.
- R2: A command is checked and acted on only when cke is high in the current cycle and was high in the previous one. In any other cycle the command changes no bank state and raises no error.
- R3: DESELECT and NOP are legal in every bank state and never raise an error.
- R4: A bank in idle (state 0) accepts ACTIVATE. READ, WRITE or a single-bank PRECHARGE sent to it is illegal with code 2.
- R5: A bank in row active (2), read burst (3) or write burst (4) accepts READ, WRITE and PRECHARGE. ACTIVATE sent to it is illegal with code 3.
- R6: An accepted ACTIVATE puts the bank in activating (1) for tRcdCfg cycles. The bank then becomes row active (2). A setting of 0 acts as 1.
- R7: An accepted PRECHARGE puts the bank in precharging (5) for tRpCfg cycles. The bank then becomes idle (0), and a setting of 0 acts as 1. PRECHARGE with apBit=1 closes every open bank and leaves idle banks idle.
- R8: An accepted READ or WRITE without auto-precharge puts the bank in read burst (3) or write burst (4) for BURST_LEN/2 cycles (BURST_LEN is 4 or 8). The bank then returns to row active. A new READ or WRITE restarts the burst.
- R9: An accepted READ or WRITE with auto-precharge puts the bank in read-close (6) or write-close (7) for BURST_LEN/2 + tRpCfg cycles. The bank then becomes idle.
- R10: While a bank is in state 1, 5, 6 or 7, an ACTIVATE, READ, WRITE or PRECHARGE to it is illegal with code 1. An all-bank PRECHARGE is also illegal with code 1 while any bank is in one of these states.
- R11: REFRESH and LOAD MODE are legal only when every bank is idle. Otherwise they are illegal with code 4. Neither command changes any bank state.
- R12: An illegal command drives illegalPulse high for exactly the following cycle, with errCode holding its reason code. It also sets errSticky, which stays set until reset, and it leaves all bank states unchanged. errCode is 0 whenever illegalPulse is low.
- R13: While reset is held and straight after it, every bank is idle and illegalPulse, errCode and errSticky are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable as seen by the device |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| bankAddr | input | BANK_W | Target bank of the command |
| apBit | input | 1 | Auto-precharge / all-bank select bit |
| tRcdCfg | input | CNT_W | Row-open delay in cycles |
| tRpCfg | input | CNT_W | Row-close delay in cycles |
| bankState | output | NUM_BANKS*3 | State of each bank, 3 bits per bank, bank 0 in the low bits |
| illegalPulse | output | 1 | One-cycle flag for an illegal command |
| errCode | output | 3 | Reason for the flagged command, 0 otherwise |
| errSticky | output | 1 | Set by any illegal command until reset |

## Verification
The hardest cases to reach are a command that lands on a bank in the middle of a timed transient, and an auto-precharge close counting down through its burst and row-close phases. The stimulus is a cycle-by-cycle vector script with fixed small timing settings, so each vector knows exactly which countdown cycle it falls on. It places illegal commands inside the activating, precharging and write-close windows and then idles until the exact cycle the bank should leave each one. An all-bank precharge is sent while two banks have been opened at staggered times and one is idle. Separate sequences drop cke around commands that would be illegal, including the first cycle after cke returns.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_OPENING = 3'd1,
    ST_ACTIVE  = 3'd2,
    ST_RDBURST = 3'd3,
    ST_WRBURST = 3'd4,
    ST_CLOSING = 3'd5,
    ST_RDCLOSE = 3'd6,
    ST_WRCLOSE = 3'd7
  } bank_st_e;

  typedef enum logic [2:0] {
    CMD_DES, CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_REF, CMD_LMR
  } cmd_e;

  typedef enum logic [2:0] {
    ERR_NONE    = 3'd0,
    ERR_BUSY    = 3'd1,
    ERR_NOROW   = 3'd2,
    ERR_ROWOPEN = 3'd3,
    ERR_NOTIDLE = 3'd4
  } err_e;

  typedef struct packed {
    logic act;
    logic rd;
    logic wr;
    logic pre;
    logic preAll;
    logic ap;
  } bank_stb_t;

  function automatic cmd_e decodeCmd(input logic [3:0] lines);
    cmd_e c;
    if (lines[3]) c = CMD_DES;
    else begin
      case (lines[2:0])
        3'b011:  c = CMD_ACT;
        3'b101:  c = CMD_RD;
        3'b100:  c = CMD_WR;
        3'b010:  c = CMD_PRE;
        3'b001:  c = CMD_REF;
        3'b000:  c = CMD_LMR;
        default: c = CMD_NOP;
      endcase
    end
    return c;
  endfunction

  function automatic logic isTransient(input bank_st_e s);
    return (s == ST_OPENING) || (s == ST_CLOSING) ||
           (s == ST_RDCLOSE) || (s == ST_WRCLOSE);
  endfunction

endpackage

// File: rtl/sdram_trk_ctrl.sv
module sdram_trk_ctrl
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int BANK_W    = $clog2(NUM_BANKS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cke,
  input  logic                         csN,
  input  logic                         rasN,
  input  logic                         casN,
  input  logic                         weN,
  input  logic [BANK_W-1:0]            bankAddr,
  input  logic                         apBit,
  input  bank_st_e [NUM_BANKS-1:0]     stVec,
  output bank_stb_t                    stb,
  output logic                         illegalPulse,
  output logic [2:0]                   errCode,
  output logic                         errSticky
);

  logic     ckePrev;
  logic     qual;
  cmd_e     cmd;
  bank_st_e tgt;
  logic     allIdle;
  logic     anyBusy;
  err_e     code;

  assign qual = ckePrev & cke;
  assign cmd  = decodeCmd({csN, rasN, casN, weN});
  assign tgt  = stVec[bankAddr];

  always_comb begin
    allIdle = 1'b1;
    anyBusy = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (stVec[b] != ST_IDLE) allIdle = 1'b0;
      if (isTransient(stVec[b])) anyBusy = 1'b1;
    end
  end

  always_comb begin
    code = ERR_NONE;
    case (cmd)
      CMD_ACT: begin
        if (isTransient(tgt))     code = ERR_BUSY;
        else if (tgt != ST_IDLE)  code = ERR_ROWOPEN;
      end
      CMD_RD, CMD_WR: begin
        if (isTransient(tgt))     code = ERR_BUSY;
        else if (tgt == ST_IDLE)  code = ERR_NOROW;
      end
      CMD_PRE: begin
        if (apBit) begin
          if (anyBusy)            code = ERR_BUSY;
        end else if (isTransient(tgt)) code = ERR_BUSY;
        else if (tgt == ST_IDLE)  code = ERR_NOROW;
      end
      CMD_REF, CMD_LMR: begin
        if (!allIdle)             code = ERR_NOTIDLE;
      end
      default: code = ERR_NONE;
    endcase
  end

  always_comb begin
    logic go;
    go         = qual && (code == ERR_NONE);
    stb.act    = go && (cmd == CMD_ACT);
    stb.rd     = go && (cmd == CMD_RD);
    stb.wr     = go && (cmd == CMD_WR);
    stb.pre    = go && (cmd == CMD_PRE);
    stb.preAll = apBit;
    stb.ap     = apBit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ckePrev      <= 1'b0;
      illegalPulse <= 1'b0;
      errCode      <= 3'd0;
      errSticky    <= 1'b0;
    end else begin
      ckePrev <= cke;
      if (qual && (code != ERR_NONE)) begin
        illegalPulse <= 1'b1;
        errCode      <= code;
        errSticky    <= 1'b1;
      end else begin
        illegalPulse <= 1'b0;
        errCode      <= 3'd0;
      end
    end
  end

endmodule

// File: rtl/sdram_trk_banks.sv
module sdram_trk_banks
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int BANK_W    = $clog2(NUM_BANKS),
  parameter int CNT_W     = 4,
  parameter int BURST_LEN = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  bank_stb_t                stb,
  input  logic [BANK_W-1:0]        bankSel,
  input  logic [CNT_W-1:0]         tRcdCfg,
  input  logic [CNT_W-1:0]         tRpCfg,
  output bank_st_e [NUM_BANKS-1:0] stVec
);

  localparam int HALF = BURST_LEN / 2;
  localparam int TW   = CNT_W + 2;

  logic [TW-1:0] rcdEff;
  logic [TW-1:0] rpEff;

  assign rcdEff = (tRcdCfg == '0) ? TW'(1) : {2'b00, tRcdCfg};
  assign rpEff  = (tRpCfg  == '0) ? TW'(1) : {2'b00, tRpCfg};

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    bank_st_e      st, stN;
    logic [TW-1:0] cnt, cntN;
    logic          sel;

    assign sel = (bankSel == BANK_W'(i));

    always_comb begin
      stN  = st;
      cntN = cnt;
      if (st != ST_IDLE && st != ST_ACTIVE) begin
        if (cnt <= TW'(1)) begin
          cntN = '0;
          if (st == ST_OPENING || st == ST_RDBURST || st == ST_WRBURST)
            stN = ST_ACTIVE;
          else
            stN = ST_IDLE;
        end else begin
          cntN = cnt - TW'(1);
        end
      end
      if (stb.act && sel) begin
        stN  = ST_OPENING;
        cntN = rcdEff;
      end else if ((stb.rd || stb.wr) && sel) begin
        if (stb.ap) begin
          stN  = stb.rd ? ST_RDCLOSE : ST_WRCLOSE;
          cntN = TW'(HALF) + rpEff;
        end else begin
          stN  = stb.rd ? ST_RDBURST : ST_WRBURST;
          cntN = TW'(HALF);
        end
      end else if (stb.pre && (sel || stb.preAll) && st != ST_IDLE) begin
        stN  = ST_CLOSING;
        cntN = rpEff;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st  <= ST_IDLE;
        cnt <= '0;
      end else begin
        st  <= stN;
        cnt <= cntN;
      end
    end

    assign stVec[i] = st;
  end

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int CNT_W     = 4,
  parameter int BURST_LEN = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cke,
  input  logic                   csN,
  input  logic                   rasN,
  input  logic                   casN,
  input  logic                   weN,
  input  logic [BANK_W-1:0]      bankAddr,
  input  logic                   apBit,
  input  logic [CNT_W-1:0]       tRcdCfg,
  input  logic [CNT_W-1:0]       tRpCfg,
  output logic [NUM_BANKS*3-1:0] bankState,
  output logic                   illegalPulse,
  output logic [2:0]             errCode,
  output logic                   errSticky
);

  bank_st_e [NUM_BANKS-1:0] stVec;
  bank_stb_t                stb;

  sdram_trk_ctrl #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cke(cke),
    .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .bankAddr(bankAddr), .apBit(apBit), .stVec(stVec),
    .stb(stb), .illegalPulse(illegalPulse), .errCode(errCode),
    .errSticky(errSticky)
  );

  sdram_trk_banks #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .CNT_W(CNT_W),
                    .BURST_LEN(BURST_LEN)) u_banks (
    .clk(clk), .rst_n(rst_n), .stb(stb), .bankSel(bankAddr),
    .tRcdCfg(tRcdCfg), .tRpCfg(tRpCfg), .stVec(stVec)
  );

  assign bankState = stVec;

endmodule

// File: rtl/sdram_cmd_tracker_chk.sv
module sdram_cmd_tracker_chk #(
  parameter int NUM_BANKS = 8,
  parameter int BANK_W    = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cke,
  input logic                   csN,
  input logic                   rasN,
  input logic                   casN,
  input logic                   weN,
  input logic [BANK_W-1:0]      bankAddr,
  input logic                   apBit,
  input logic [NUM_BANKS*3-1:0] bankState,
  input logic                   illegalPulse,
  input logic [2:0]             errCode,
  input logic                   errSticky
);

  logic              ckeSeen;
  logic [BANK_W-1:0] bankQ;
  logic              chkQual;
  logic [2:0]        tgtNow;
  logic [2:0]        tgtPrevBank;
  logic              isNopLike;
  logic              tgtCmd;
  logic              tgtBusy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ckeSeen <= 1'b0;
      bankQ   <= '0;
    end else begin
      ckeSeen <= cke;
      bankQ   <= bankAddr;
    end
  end

  assign chkQual     = ckeSeen && cke;
  assign tgtNow      = bankState[bankAddr*3 +: 3];
  assign tgtPrevBank = bankState[bankQ*3 +: 3];
  assign isNopLike   = csN || ({rasN, casN, weN} == 3'b111) || ({rasN, casN, weN} == 3'b110);
  assign tgtCmd      = !csN && (({rasN, casN, weN} == 3'b011) || ({rasN, casN} == 2'b10) ||
                                (({rasN, casN, weN} == 3'b010) && !apBit));
  assign tgtBusy     = (tgtNow == 3'd1) || (tgtNow == 3'd5) || (tgtNow == 3'd6) || (tgtNow == 3'd7);

  // R2: no error unless cke was high on two consecutive samples
  a_r2_cke_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    !chkQual |=> !illegalPulse);

  // R3: DESELECT and NOP never flagged
  a_r3_nop_legal: assert property (@(posedge clk) disable iff (!rst_n)
    isNopLike |=> !illegalPulse);

  // R6: accepted ACTIVATE enters the opening state
  a_r6_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (chkQual && !csN && {rasN, casN, weN} == 3'b011 && tgtNow == 3'd0) |=> (tgtPrevBank == 3'd1));

  // R10: commands into a transient bank are flagged as busy
  a_r10_busy_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (chkQual && tgtCmd && tgtBusy) |=> (illegalPulse && errCode == 3'd1));

  // R12: sticky flag follows any pulse and never clears
  a_r12_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
    illegalPulse |-> errSticky);

  a_r12_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    errSticky |=> errSticky);

  // R12: code is zero exactly when no pulse
  a_r12_code_idle: assert property (@(posedge clk) disable iff (!rst_n)
    illegalPulse == (errCode != 3'd0));

endmodule

bind sdram_cmd_tracker sdram_cmd_tracker_chk #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
  .weN(weN), .bankAddr(bankAddr), .apBit(apBit), .bankState(bankState),
  .illegalPulse(illegalPulse), .errCode(errCode), .errSticky(errSticky)
);

// File: tb/sim_sdram_cmd_tracker.sv
`timescale 1ns/1ps
module sim_sdram_cmd_tracker;

  localparam int NB = 8;
  localparam int BW = 3;
  localparam int CW = 4;

  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                         C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001,
                         C_LMR = 4'b0000, C_DES = 4'b1111;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke = 1'b1;
  logic csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [BW-1:0] bankAddr = '0;
  logic apBit = 1'b0;
  logic [CW-1:0] tRcdCfg = 4'd3;
  logic [CW-1:0] tRpCfg = 4'd2;
  logic [NB*3-1:0] bankState;
  logic illegalPulse;
  logic [2:0] errCode;
  logic errSticky;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  sdram_cmd_tracker #(.NUM_BANKS(NB), .CNT_W(CW), .BURST_LEN(4)) u0 (
    .clk(clk), .rst_n(rst_n), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .bankAddr(bankAddr), .apBit(apBit), .tRcdCfg(tRcdCfg),
    .tRpCfg(tRpCfg), .bankState(bankState), .illegalPulse(illegalPulse),
    .errCode(errCode), .errSticky(errSticky)
  );

  // fields: cmd[14:11] bank[10:8] ap[7] expIll[6] expCode[5:3] expSt[2:0]
  localparam int NV = 37;
  localparam logic [14:0] VEC [NV] = '{
    {C_REF, 3'd0, 1'b0, 1'b0, 3'd0, 3'd0},  // R11 all idle
    {C_LMR, 3'd0, 1'b0, 1'b0, 3'd0, 3'd0},  // R11
    {C_RD,  3'd0, 1'b0, 1'b1, 3'd2, 3'd0},  // R4
    {C_ACT, 3'd0, 1'b0, 1'b0, 3'd0, 3'd1},  // R4 R6
    {C_RD,  3'd0, 1'b0, 1'b1, 3'd1, 3'd1},  // R10
    {C_NOP, 3'd0, 1'b0, 1'b0, 3'd0, 3'd1},  // R6
    {C_NOP, 3'd0, 1'b0, 1'b0, 3'd0, 3'd2},  // R6 tRCD=3
    {C_ACT, 3'd0, 1'b0, 1'b1, 3'd3, 3'd2},  // R5
    {C_RD,  3'd0, 1'b0, 1'b0, 3'd0, 3'd3},  // R8
    {C_NOP, 3'd0, 1'b0, 1'b0, 3'd0, 3'd3},  // R8
    {C_NOP, 3'd0, 1'b0, 1'b0, 3'd0, 3'd2},  // R8 BL/2=2
    {C_WR,  3'd0, 1'b0, 1'b0, 3'd0, 3'd4},  // R5 R8
    {C_RD,  3'd0, 1'b0, 1'b0, 3'd0, 3'd3},  // R8 restart
    {C_REF, 3'd0, 1'b0, 1'b1, 3'd4, 3'd3},  // R11
    {C_NOP, 3'd0, 1'b0, 1'b0, 3'd0, 3'd2},  // R8
    {C_PRE, 3'd0, 1'b0, 1'b0, 3'd0, 3'd5},  // R7
    {C_ACT, 3'd0, 1'b0, 1'b1, 3'd1, 3'd5},  // R10
    {C_NOP, 3'd0, 1'b0, 1'b0, 3'd0, 3'd0},  // R7 tRP=2
    {C_ACT, 3'd1, 1'b0, 1'b0, 3'd0, 3'd1},  // R6
    {C_NOP, 3'd1, 1'b0, 1'b0, 3'd0, 3'd1},
    {C_NOP, 3'd1, 1'b0, 1'b0, 3'd0, 3'd1},
    {C_NOP, 3'd1, 1'b0, 1'b0, 3'd0, 3'd2},  // R6
    {C_WR,  3'd1, 1'b1, 1'b0, 3'd0, 3'd7},  // R9
    {C_NOP, 3'd1, 1'b0, 1'b0, 3'd0, 3'd7},
    {C_WR,  3'd1, 1'b0, 1'b1, 3'd1, 3'd7},  // R10
    {C_NOP, 3'd1, 1'b0, 1'b0, 3'd0, 3'd7},
    {C_NOP, 3'd1, 1'b0, 1'b0, 3'd0, 3'd0},  // R9 2+2 cycles
    {C_DES, 3'd1, 1'b0, 1'b0, 3'd0, 3'd0},  // R3
    {C_PRE, 3'd2, 1'b0, 1'b1, 3'd2, 3'd0},  // R4
    {C_ACT, 3'd2, 1'b0, 1'b0, 3'd0, 3'd1},
    {C_ACT, 3'd3, 1'b0, 1'b0, 3'd0, 3'd1},
    {C_NOP, 3'd2, 1'b0, 1'b0, 3'd0, 3'd1},
    {C_NOP, 3'd2, 1'b0, 1'b0, 3'd0, 3'd2},
    {C_NOP, 3'd3, 1'b0, 1'b0, 3'd0, 3'd2},
    {C_PRE, 3'd2, 1'b1, 1'b0, 3'd0, 3'd5},  // R7 all-bank
    {C_NOP, 3'd3, 1'b0, 1'b0, 3'd0, 3'd5},
    {C_NOP, 3'd3, 1'b0, 1'b0, 3'd0, 3'd0}   // R7
  };

  function automatic logic [2:0] stOf(input int b);
    return bankState[b*3 +: 3];
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic [3:0] c, input logic [BW-1:0] b, input logic ap);
    {csN, rasN, casN, weN} = c;
    bankAddr = b;
    apBit = ap;
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset;
    rst_n = 1'b0;
    drive(C_NOP, 3'd0, 1'b0);
    cke = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    step();
    step();
  endtask

  initial begin
    #1500000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R13: values during reset
    check("R13 state in reset", {5'd0, bankState[2:0]} | {5'd0, bankState[23:21]}, 8'd0);
    check("R13 pulse in reset", {7'd0, illegalPulse}, 8'd0);
    doReset();
    check("R13 all idle", {7'd0, (bankState == '0)}, 8'd1);
    check("R13 sticky", {7'd0, errSticky}, 8'd0);
    check("R13 code", {5'd0, errCode}, 8'd0);

    for (int i = 0; i < NV; i++) begin
      logic [14:0] v;
      v = VEC[i];
      drive(v[14:11], v[10:8], v[7]);
      step();
      check($sformatf("R12 pulse vec%0d", i), {7'd0, illegalPulse}, {7'd0, v[6]});
      check($sformatf("R12 code vec%0d", i), {5'd0, errCode}, {5'd0, v[5:3]});
      check($sformatf("R1 state vec%0d", i), {5'd0, stOf(int'(v[10:8]))}, {5'd0, v[2:0]});
    end
    drive(C_NOP, 3'd0, 1'b0);
    step();
    check("R12 sticky after errors", {7'd0, errSticky}, 8'd1);
    check("R12 pulse single cycle", {7'd0, illegalPulse}, 8'd0);
    check("R11 refresh left banks idle", {7'd0, (bankState == '0)}, 8'd1);

    doReset();
    check("R13 sticky cleared", {7'd0, errSticky}, 8'd0);

    // R2: cke low, illegal READ to idle bank ignored
    cke = 1'b0;
    drive(C_RD, 3'd4, 1'b0);
    step();
    check("R2 no pulse cke low", {7'd0, illegalPulse}, 8'd0);
    drive(C_ACT, 3'd4, 1'b0);
    step();
    check("R2 act ignored cke low", {5'd0, stOf(4)}, 8'd0);
    // first cycle after cke returns is still bypassed
    cke = 1'b1;
    step();
    check("R2 act ignored first cke cycle", {5'd0, stOf(4)}, 8'd0);
    check("R2 sticky untouched", {7'd0, errSticky}, 8'd0);
    step();
    check("R2 act taken after two cke", {5'd0, stOf(4)}, 8'd1);

    // R6: zero tRCD acts as one
    drive(C_NOP, 3'd0, 1'b0);
    repeat (3) step();
    tRcdCfg = 4'd0;
    drive(C_ACT, 3'd5, 1'b0);
    step();
    check("R6 zero rcd opening", {5'd0, stOf(5)}, 8'd1);
    drive(C_NOP, 3'd5, 1'b0);
    step();
    check("R6 zero rcd active", {5'd0, stOf(5)}, 8'd2);

    // R9: read with auto-precharge, BL/2 + tRP = 4 cycles
    drive(C_RD, 3'd5, 1'b1);
    step();
    check("R9 read close entered", {5'd0, stOf(5)}, 8'd6);
    drive(C_NOP, 3'd5, 1'b0);
    repeat (3) step();
    check("R9 read close still", {5'd0, stOf(5)}, 8'd6);
    step();
    check("R9 read close idle", {5'd0, stOf(5)}, 8'd0);

    // R10: all-bank precharge while a bank is opening
    tRcdCfg = 4'd3;
    drive(C_ACT, 3'd6, 1'b0);
    step();
    drive(C_PRE, 3'd0, 1'b1);
    step();
    check("R10 prea busy pulse", {7'd0, illegalPulse}, 8'd1);
    check("R10 prea busy code", {5'd0, errCode}, 8'd1);
    check("R10 bank4 unchanged", {5'd0, stOf(4)}, 8'd2);

    drive(C_NOP, 3'd0, 1'b0);
    step();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule